// File: doc/BRIEF.md
# Display Controller Shadowed Register Port

This block is a small indexed register file for a display controller. It holds the vertical retrace start byte, the retrace end and interrupt control byte, a 16-bit light pen address latch, and two fixed chip revision bytes. Software reaches the storage through two index/data port pairs: a standard controller space and an extension space. Each space has its own 8-bit index register.

In the standard space the two retrace registers can only be written. A read at either of their indices returns a light pen byte instead. The extension space exposes the same retrace storage and the light pen bytes with full read and write access, so that software can save and restore the controller state. The extension space also holds the two revision bytes, which cannot be written.

The light pen latch takes in an asynchronous pen strobe through a synchronizer. On a rising edge it captures the current display memory address. A legacy narrow-address mode forces the two top captured bits to zero. Once loaded, the latch holds its value until software clears it.

Top module: `crtc_shadow_regs`

## Requirements
- R1: After reset the retrace start register is 0x00, the retrace end register is 0x20 (bit 5, interrupt disable, is 1 and bit 4, interrupt clear, is 0), the light pen latch is 0x0000 with its full flag low, and both index registers are 0x00.
- R2: Extension indices 0x8E and 0x8F always read 0xAF. Data writes at those indices change nothing.
- R3: A standard-space data write at index 0x10 loads the retrace start register. A standard-space read at index 0x10 returns light pen address bits 15:8.
- R4: A standard-space data write at index 0x11 loads the retrace end register. A standard-space read at index 0x11 returns light pen address bits 7:0.
- R5: Extension index 0x90 reads and writes the retrace start register, and extension index 0x91 reads and writes the retrace end register. This is the same storage that standard indices 0x10 and 0x11 write.
- R6: Extension index 0x92 reads and writes light pen bits 15:8, and extension index 0x93 reads and writes bits 7:0.
- R7: A rising edge on the pen strobe, held for at least SYNC_STAGES+2 clocks, loads the memory address into the latch while the full flag is low, and sets the full flag.
- R8: While the full flag is high, further pen strobes leave the latch unchanged. A one-clock clear pulse drops the full flag so that the next strobe is captured.
- R9: With narrow mode high, a capture loads bits 15:14 of the latch as 0 and the lower 14 bits from the memory address.
- R10: Reads at indices that are not implemented in either space return 0x00. Data writes at those indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdata | input | 8 | Write data shared by the index and data strobes |
| std_idx_we | input | 1 | Load the standard-space index from wdata |
| std_data_we | input | 1 | Data write at the current standard index |
| ext_idx_we | input | 1 | Load the extension-space index from wdata |
| ext_data_we | input | 1 | Data write at the current extension index |
| std_rdata | output | 8 | Read data at the current standard index |
| ext_rdata | output | 8 | Read data at the current extension index |
| lpen_strobe | input | 1 | Asynchronous light pen strobe |
| lpen_clr | input | 1 | Clears the latch full flag |
| narrow_mode | input | 1 | Legacy 14-bit address capture |
| mem_addr | input | 16 | Current display memory address |
| lpen_full | output | 1 | Latch holds a captured address |
| vrs_out | output | 8 | Retrace start value to the timing logic |
| vre_out | output | 8 | Retrace end and interrupt control byte |

## Verification
The same bytes are written through one space and read back through the other, in both directions. This separates shared storage from two independent copies, and it separates the standard-space light pen read-back from a plain echo of the retrace registers. Light pen captures are tried with a wide address, then with a second strobe while the latch is full, then with an all-ones address in narrow mode. These cases tell a working hold and clear apart from an overwrite, and show whether the top-bit masking is applied. Writes at unused indices and at the revision indices are followed by reads of every retrace and latch output, which would show any stray update.

// File: rtl/crtc_shadow_pkg.sv
package crtc_shadow_pkg;

   localparam logic [7:0] STD_IX_VRS = 8'h10;
   localparam logic [7:0] STD_IX_VRE = 8'h11;
   localparam logic [7:0] EXT_IX_REV0 = 8'h8E;
   localparam logic [7:0] EXT_IX_REV1 = 8'h8F;
   localparam logic [7:0] EXT_IX_VRS = 8'h90;
   localparam logic [7:0] EXT_IX_VRE = 8'h91;
   localparam logic [7:0] EXT_IX_LPH = 8'h92;
   localparam logic [7:0] EXT_IX_LPL = 8'h93;

   // one-hot decode of both index spaces
   typedef struct packed {
      logic std_vrs;
      logic std_vre;
      logic ext_rev0;
      logic ext_rev1;
      logic ext_vrs;
      logic ext_vre;
      logic ext_lph;
      logic ext_lpl;
   } idx_sel_t;

   // retrace end / interrupt control byte layout
   typedef struct packed {
      logic       test_hi;
      logic       test_lo;
      logic       vint_dis;
      logic       vint_clr_n;
      logic [3:0] vend;
   } vre_t;

endpackage

// File: rtl/crtc_idx_decode.sv
module crtc_idx_decode
   import crtc_shadow_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wdata,
   input  logic          std_idx_we,
   input  logic          ext_idx_we,
   output logic [DW-1:0] std_idx,
   output logic [DW-1:0] ext_idx,
   output idx_sel_t      sel
);

   logic [DW-1:0] std_idx_q;
   logic [DW-1:0] ext_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         std_idx_q <= '0;
         ext_idx_q <= '0;
      end else begin
         if (std_idx_we) std_idx_q <= wdata;
         if (ext_idx_we) ext_idx_q <= wdata;
      end
   end

   always_comb begin
      sel          = '0;
      sel.std_vrs  = (std_idx_q == STD_IX_VRS);
      sel.std_vre  = (std_idx_q == STD_IX_VRE);
      sel.ext_rev0 = (ext_idx_q == EXT_IX_REV0);
      sel.ext_rev1 = (ext_idx_q == EXT_IX_REV1);
      sel.ext_vrs  = (ext_idx_q == EXT_IX_VRS);
      sel.ext_vre  = (ext_idx_q == EXT_IX_VRE);
      sel.ext_lph  = (ext_idx_q == EXT_IX_LPH);
      sel.ext_lpl  = (ext_idx_q == EXT_IX_LPL);
   end

   assign std_idx = std_idx_q;
   assign ext_idx = ext_idx_q;

endmodule

// File: rtl/crtc_retrace_regs.sv
module crtc_retrace_regs
   import crtc_shadow_pkg::*;
#(
   parameter int          DW        = 8,
   parameter logic [7:0]  VRE_RESET = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wdata,
   input  logic          ld_vrs,
   input  logic          ld_vre,
   output logic [DW-1:0] vrs_q,
   output vre_t          vre_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vrs_q <= '0;
         vre_q <= vre_t'(VRE_RESET);
      end else begin
         if (ld_vrs) vrs_q <= wdata;
         if (ld_vre) vre_q <= vre_t'(wdata);
      end
   end

endmodule

// File: rtl/crtc_lpen_latch.sv
module crtc_lpen_latch #(
   parameter int DW          = 8,
   parameter int AW          = 16,
   parameter int NARROW_AW   = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic          clr,
   input  logic          narrow,
   input  logic [AW-1:0] mem_addr,
   input  logic          wr_hi,
   input  logic          wr_lo,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] addr_q,
   output logic          full_q,
   output logic          cap
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;
   logic [AW-1:0]          cap_addr;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= strobe;
         end
      end else begin : g_syncn
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe};
         end
      end

      if (NARROW_AW < AW) begin : g_mask
         assign cap_addr = narrow ? {{(AW-NARROW_AW){1'b0}}, mem_addr[NARROW_AW-1:0]}
                                  : mem_addr;
      end else begin : g_nomask
         logic unused_narrow;
         assign unused_narrow = narrow;
         assign cap_addr      = mem_addr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign cap  = rise & ~full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         addr_q <= '0;
      end else begin
         if (cap)      full_q <= 1'b1;
         else if (clr) full_q <= 1'b0;
         if (cap) begin
            addr_q <= cap_addr;
         end else begin
            if (wr_hi) addr_q[AW-1:DW] <= wdata;
            if (wr_lo) addr_q[DW-1:0]  <= wdata;
         end
      end
   end

endmodule

// File: rtl/crtc_shadow_regs.sv
module crtc_shadow_regs
   import crtc_shadow_pkg::*;
#(
   parameter int         DW          = 8,
   parameter int         AW          = 16,
   parameter int         NARROW_AW   = 14,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] REV_VALUE   = 8'hAF,
   parameter logic [7:0] VRE_RESET   = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wdata,
   input  logic          std_idx_we,
   input  logic          std_data_we,
   input  logic          ext_idx_we,
   input  logic          ext_data_we,
   output logic [DW-1:0] std_rdata,
   output logic [DW-1:0] ext_rdata,
   input  logic          lpen_strobe,
   input  logic          lpen_clr,
   input  logic          narrow_mode,
   input  logic [AW-1:0] mem_addr,
   output logic          lpen_full,
   output logic [DW-1:0] vrs_out,
   output logic [DW-1:0] vre_out
);

   localparam int HI_W = AW - DW;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("crtc_shadow_regs: DW must be 8");
      end
      if (AW != 2 * DW) begin : g_bad_aw
         $error("crtc_shadow_regs: AW must be twice DW");
      end
      if (NARROW_AW < 1 || NARROW_AW > AW) begin : g_bad_naw
         $error("crtc_shadow_regs: NARROW_AW out of range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("crtc_shadow_regs: SYNC_STAGES must be at least 1");
      end
   endgenerate

   idx_sel_t      sel;
   logic [DW-1:0] std_idx;
   logic [DW-1:0] ext_idx;
   logic [DW-1:0] vrs_q;
   vre_t          vre_q;
   logic [AW-1:0] lpen_q;
   logic          lpen_cap;
   logic          ld_vrs, ld_vre, ld_lph, ld_lpl;

   crtc_idx_decode #(.DW(DW)) u_idx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata      (wdata),
      .std_idx_we (std_idx_we),
      .ext_idx_we (ext_idx_we),
      .std_idx    (std_idx),
      .ext_idx    (ext_idx),
      .sel        (sel)
   );

   assign ld_vrs = (std_data_we & sel.std_vrs) | (ext_data_we & sel.ext_vrs);
   assign ld_vre = (std_data_we & sel.std_vre) | (ext_data_we & sel.ext_vre);
   assign ld_lph = ext_data_we & sel.ext_lph;
   assign ld_lpl = ext_data_we & sel.ext_lpl;

   crtc_retrace_regs #(.DW(DW), .VRE_RESET(VRE_RESET)) u_rtr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wdata  (wdata),
      .ld_vrs (ld_vrs),
      .ld_vre (ld_vre),
      .vrs_q  (vrs_q),
      .vre_q  (vre_q)
   );

   crtc_lpen_latch #(
      .DW(DW), .AW(AW), .NARROW_AW(NARROW_AW), .SYNC_STAGES(SYNC_STAGES)
   ) u_lpen (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (lpen_strobe),
      .clr      (lpen_clr),
      .narrow   (narrow_mode),
      .mem_addr (mem_addr),
      .wr_hi    (ld_lph),
      .wr_lo    (ld_lpl),
      .wdata    (wdata),
      .addr_q   (lpen_q),
      .full_q   (lpen_full),
      .cap      (lpen_cap)
   );

   logic [HI_W-1:0] lpen_hi;
   logic [DW-1:0]   lpen_lo;
   assign lpen_hi = lpen_q[AW-1:DW];
   assign lpen_lo = lpen_q[DW-1:0];

   // standard space: retrace indices read back the light pen bytes
   always_comb begin
      std_rdata = '0;
      if (sel.std_vrs)      std_rdata = lpen_hi;
      else if (sel.std_vre) std_rdata = lpen_lo;
   end

   // extension space: full read-back for state save/restore
   always_comb begin
      ext_rdata = '0;
      unique case (1'b1)
         sel.ext_rev0,
         sel.ext_rev1: ext_rdata = REV_VALUE;
         sel.ext_vrs:  ext_rdata = vrs_q;
         sel.ext_vre:  ext_rdata = vre_q;
         sel.ext_lph:  ext_rdata = lpen_hi;
         sel.ext_lpl:  ext_rdata = lpen_lo;
         default:      ext_rdata = '0;
      endcase
   end

   assign vrs_out = vrs_q;
   assign vre_out = vre_q;

endmodule

// File: rtl/crtc_shadow_chk.sv
module crtc_shadow_chk #(
   parameter int         DW        = 8,
   parameter int         AW        = 16,
   parameter int         NARROW_AW = 14,
   parameter logic [7:0] REV_VALUE = 8'hAF
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] wdata,
   input logic          std_data_we,
   input logic          ext_data_we,
   input logic [DW-1:0] std_idx,
   input logic [DW-1:0] ext_idx,
   input logic [DW-1:0] std_rdata,
   input logic [DW-1:0] ext_rdata,
   input logic [DW-1:0] vrs_out,
   input logic [DW-1:0] vre_out,
   input logic [AW-1:0] lpen_q,
   input logic          lpen_full,
   input logic          lpen_cap,
   input logic          narrow_mode
);

   // R2
   rev_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_idx == 8'h8E || ext_idx == 8'h8F) |-> ext_rdata == REV_VALUE);

   // R3
   std_vrs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (std_data_we && std_idx == 8'h10) |=> vrs_out == $past(wdata));

   // R3
   std_vrs_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (std_idx == 8'h10) |-> std_rdata == lpen_q[AW-1:DW]);

   // R5
   ext_vre_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_data_we && ext_idx == 8'h91) |=> vre_out == $past(wdata));

   // R8
   lpen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lpen_full && !(ext_data_we && (ext_idx == 8'h92 || ext_idx == 8'h93)))
      |=> $stable(lpen_q));

   // R9
   narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lpen_cap && narrow_mode) |=> lpen_q[AW-1:NARROW_AW] == '0);

   // R10
   std_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (std_idx != 8'h10 && std_idx != 8'h11) |-> std_rdata == '0);

endmodule

bind crtc_shadow_regs crtc_shadow_chk #(
   .DW(DW), .AW(AW), .NARROW_AW(NARROW_AW), .REV_VALUE(REV_VALUE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wdata       (wdata),
   .std_data_we (std_data_we),
   .ext_data_we (ext_data_we),
   .std_idx     (std_idx),
   .ext_idx     (ext_idx),
   .std_rdata   (std_rdata),
   .ext_rdata   (ext_rdata),
   .vrs_out     (vrs_out),
   .vre_out     (vre_out),
   .lpen_q      (lpen_q),
   .lpen_full   (lpen_full),
   .lpen_cap    (lpen_cap),
   .narrow_mode (narrow_mode)
);

// File: tb/tb_crtc_shadow_regs.sv
`timescale 1ns/1ps
module tb_crtc_shadow_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  wdata = '0;
   logic        std_idx_we = 1'b0, std_data_we = 1'b0;
   logic        ext_idx_we = 1'b0, ext_data_we = 1'b0;
   logic [7:0]  std_rdata, ext_rdata, vrs_out, vre_out;
   logic        lpen_strobe = 1'b0, lpen_clr = 1'b0, narrow_mode = 1'b0;
   logic [15:0] mem_addr = '0;
   logic        lpen_full;

   always #2 clk = ~clk;

   crtc_shadow_regs dut (
      .clk(clk), .rst_n(rst_n), .wdata(wdata),
      .std_idx_we(std_idx_we), .std_data_we(std_data_we),
      .ext_idx_we(ext_idx_we), .ext_data_we(ext_data_we),
      .std_rdata(std_rdata), .ext_rdata(ext_rdata),
      .lpen_strobe(lpen_strobe), .lpen_clr(lpen_clr),
      .narrow_mode(narrow_mode), .mem_addr(mem_addr),
      .lpen_full(lpen_full), .vrs_out(vrs_out), .vre_out(vre_out)
   );

   // kinds: 0 std_rdata, 1 ext_rdata, 2 vrs_out, 3 vre_out, 4 lpen_full
   typedef struct {
      int         kind;
      int         req;
      logic [7:0] exp;
   } item_t;

   item_t q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic push(int kind, int req, logic [7:0] exp);
      item_t it;
      it.kind = kind; it.req = req; it.exp = exp;
      q.push_back(it);
      @(negedge clk);
   endtask

   // monitor: compares one item per cycle, just after the edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = q.pop_front();
         case (it.kind)
            0: act = std_rdata;
            1: act = ext_rdata;
            2: act = vrs_out;
            3: act = vre_out;
            default: act = {7'd0, lpen_full};
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL R%0d kind %0d actual %02h expected %02h",
                     it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic set_idx(bit ext, logic [7:0] v);
      @(negedge clk);
      wdata = v;
      if (ext) ext_idx_we = 1'b1; else std_idx_we = 1'b1;
      @(negedge clk);
      ext_idx_we = 1'b0; std_idx_we = 1'b0;
   endtask

   task automatic wr(bit ext, logic [7:0] v);
      @(negedge clk);
      wdata = v;
      if (ext) ext_data_we = 1'b1; else std_data_we = 1'b1;
      @(negedge clk);
      ext_data_we = 1'b0; std_data_we = 1'b0;
   endtask

   task automatic rd(bit ext, logic [7:0] idx, int req, logic [7:0] exp);
      set_idx(ext, idx);
      push(ext ? 1 : 0, req, exp);
   endtask

   task automatic pen(logic [15:0] a);
      @(negedge clk);
      mem_addr = a;
      lpen_strobe = 1'b1;
      repeat (8) @(negedge clk);
      lpen_strobe = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_pen();
      @(negedge clk);
      lpen_clr = 1'b1;
      @(negedge clk);
      lpen_clr = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      push(2, 1, 8'h00);
      push(3, 1, 8'h20);
      push(4, 1, 8'h00);
      push(0, 1, 8'h00);       // standard index 0x00 reads 0
      rd(1, 8'h91, 1, 8'h20);
      rd(1, 8'h92, 1, 8'h00);

      // R2 revision bytes fixed, writes ignored
      rd(1, 8'h8E, 2, 8'hAF);
      wr(1, 8'h12);
      push(1, 2, 8'hAF);
      push(2, 2, 8'h00);
      push(3, 2, 8'h20);
      rd(1, 8'h8F, 2, 8'hAF);

      // R3 standard write 0x10, read-back is light pen high
      set_idx(0, 8'h10);
      wr(0, 8'h5A);
      push(2, 3, 8'h5A);
      push(0, 3, 8'h00);
      rd(1, 8'h90, 3, 8'h5A);

      // R4 standard write 0x11, read-back is light pen low
      set_idx(0, 8'h11);
      wr(0, 8'h0C);
      push(3, 4, 8'h0C);
      push(0, 4, 8'h00);
      rd(1, 8'h91, 4, 8'h0C);

      // R5 extension access to retrace storage
      set_idx(1, 8'h90);
      wr(1, 8'h77);
      push(1, 5, 8'h77);
      push(2, 5, 8'h77);
      set_idx(1, 8'h91);
      wr(1, 8'h3F);
      push(1, 5, 8'h3F);
      push(3, 5, 8'h3F);

      // R6 extension access to light pen bytes
      set_idx(1, 8'h92);
      wr(1, 8'hBE);
      push(1, 6, 8'hBE);
      set_idx(1, 8'h93);
      wr(1, 8'hEF);
      push(1, 6, 8'hEF);
      rd(0, 8'h10, 6, 8'hBE);
      rd(0, 8'h11, 6, 8'hEF);
      push(4, 6, 8'h00);

      // R7 capture
      pen(16'hC3A5);
      push(4, 7, 8'h01);
      rd(1, 8'h92, 7, 8'hC3);
      rd(1, 8'h93, 7, 8'hA5);

      // R8 hold while full, then clear
      pen(16'h1234);
      rd(1, 8'h92, 8, 8'hC3);
      push(1, 8, 8'hC3);
      rd(1, 8'h93, 8, 8'hA5);
      clear_pen();
      push(4, 8, 8'h00);
      pen(16'h1234);
      rd(1, 8'h92, 8, 8'h12);
      clear_pen();

      // R9 narrow mode masks bits 15:14
      narrow_mode = 1'b1;
      pen(16'hFFFF);
      rd(1, 8'h92, 9, 8'h3F);
      rd(1, 8'h93, 9, 8'hFF);
      narrow_mode = 1'b0;

      // R10 unused indices
      rd(1, 8'h55, 10, 8'h00);
      wr(1, 8'hA1);
      push(2, 10, 8'h77);
      push(3, 10, 8'h3F);
      rd(1, 8'h92, 10, 8'h3F);
      rd(1, 8'h93, 10, 8'hFF);
      rd(0, 8'h12, 10, 8'h00);
      wr(0, 8'hC4);
      push(2, 10, 8'h77);
      push(3, 10, 8'h3F);
      rd(1, 8'h8D, 10, 8'h00);

      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule